// File: doc/BRIEF.md
# Asynchronous Serial Receiver with Error Flags

This block is the receive half of an asynchronous serial link. It watches the serial input for a low start bit and confirms it at mid-bit. It then samples each following bit at its centre, using a 16x oversample enable that arrives from an external rate generator. Each bit lands in a shift register. At the end of the frame it checks parity and the stop bit or bits.

A clean frame moves the character into the data register and raises the data-full flag. A frame with a fault leaves the data register and the data-full flag alone and raises the matching error flag instead. There are three error kinds: overrun, framing and parity.

Configuration inputs select 7 or 8 data bits, parity off, even or odd, and one or two stop bits. With two stop bits, a further input chooses whether both stop bits are checked or only the first. Two level interrupt requests, one for receive complete and one for receive error, share a single enable. Software clears a flag by first strobing a status read and then strobing the write that clears it. A transfer-controller read strobe also empties the data register.

Top module: `serial_rx_core`

## Requirements
- R1: While `rx_en` is 0 the receiver stays idle; a frame sent on `rxd` changes no flag and no data.
- R2: A low level on `rxd` starts a frame only if `rxd` is still 0 at the 8th oversample tick after detection; a shorter low pulse is dropped with no flag change.
- R3: A clean frame writes the character to `rx_data`, sets `full` and leaves all error flags at 0. Data bits arrive least significant bit first. The frame is a 0 start bit, the data bits, an optional parity bit, then the stop bits.
- R4: A frame with any error never sets `full` and never changes `rx_data`.
- R5: With `cfg_len7`=1, seven data bits are received and `rx_data[7]` reads 0.
- R6: With `cfg_par_en`=1, a parity bit follows the data. `cfg_par_odd`=0 means the data bits and the parity bit together hold an even number of ones; `cfg_par_odd`=1 means an odd number. A mismatch sets `err_par`.
- R7: A 0 in the first stop bit sets `err_frm`.
- R8: With `cfg_two_stop`=1, a 0 in the second stop bit sets `err_frm` only when `cfg_chk_both`=1; with `cfg_chk_both`=0 the frame is clean.
- R9: A frame that completes while `full` is 1 sets `err_ovr`, keeps the old `rx_data` and leaves `full` at 1.
- R10: `clr_full_wr` clears `full`, and `clr_err_wr` clears all three error flags, only when `stat_rd` was pulsed since the last clear write; a clear write without a prior status read has no effect.
- R11: A pulse on `xfer_rd` clears `full` directly.
- R12: `irq_done` is 1 while `full` and `irq_en` are both 1. `irq_err` is 1 while any error flag and `irq_en` are 1. Both are 0 when `irq_en` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| rx_en | input | 1 | Receiver enable |
| tick16 | input | 1 | 16x oversample enable, one clock wide |
| rxd | input | 1 | Serial input, idle high |
| cfg_len7 | input | 1 | 1: 7 data bits, 0: 8 |
| cfg_par_en | input | 1 | Parity bit present |
| cfg_par_odd | input | 1 | 1: odd parity, 0: even |
| cfg_two_stop | input | 1 | Two stop bits |
| cfg_chk_both | input | 1 | Check both stop bits when two are used |
| irq_en | input | 1 | Interrupt enable for both requests |
| stat_rd | input | 1 | Status read strobe, arms clearing |
| clr_full_wr | input | 1 | Write strobe that clears data-full |
| clr_err_wr | input | 1 | Write strobe that clears error flags |
| xfer_rd | input | 1 | Transfer-controller read strobe |
| rx_data | output | 8 | Received character |
| full | output | 1 | Data-full flag |
| err_ovr | output | 1 | Overrun error flag |
| err_frm | output | 1 | Framing error flag |
| err_par | output | 1 | Parity error flag |
| irq_done | output | 1 | Receive-complete interrupt request |
| irq_err | output | 1 | Receive-error interrupt request |

## Verification
The hardest case to reach is overrun. It needs a second complete frame while the first character is still unread. The stimulus therefore sends two back-to-back frames and issues no clear strobe in between, then checks that the first character survives. The false start bit is also hard to reach. The bench holds `rxd` low for three oversample ticks, which is well short of the mid-bit sample, and checks that no flag moves. The second-stop-bit case sends a frame whose only fault is a 0 in the second stop bit, once with each setting of the check-both input.

// File: rtl/serial_rx_core.sv
module serial_rx_core #(
  parameter int OSR = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       rx_en,
  input  logic       tick16,
  input  logic       rxd,
  input  logic       cfg_len7,
  input  logic       cfg_par_en,
  input  logic       cfg_par_odd,
  input  logic       cfg_two_stop,
  input  logic       cfg_chk_both,
  input  logic       irq_en,
  input  logic       stat_rd,
  input  logic       clr_full_wr,
  input  logic       clr_err_wr,
  input  logic       xfer_rd,
  output logic [7:0] rx_data,
  output logic       full,
  output logic       err_ovr,
  output logic       err_frm,
  output logic       err_par,
  output logic       irq_done,
  output logic       irq_err
);
  localparam int CW = $clog2(OSR);
  localparam logic [CW-1:0] MID = CW'(OSR / 2 - 1);
  localparam logic [CW-1:0] LAST = CW'(OSR - 1);

  typedef enum logic [1:0] {IDLE, START, BITS, DONE} st_t;
  st_t st;

  logic [CW-1:0] cnt;
  logic [3:0]    bidx;
  logic [11:0]   sr;
  logic          armed;

  wire [3:0] dlen  = cfg_len7 ? 4'd7 : 4'd8;
  wire [3:0] s1    = dlen + {3'd0, cfg_par_en};
  wire [3:0] nbits = s1 + 4'd1 + {3'd0, cfg_two_stop};
  wire [7:0] dat   = cfg_len7 ? {1'b0, sr[6:0]} : sr[7:0];
  wire       par_bad = cfg_par_en & ((^dat ^ sr[dlen]) != cfg_par_odd);
  wire       frm_bad = ~sr[s1] | (cfg_two_stop & cfg_chk_both & ~sr[s1 + 4'd1]);
  wire       done  = (st == DONE);

  assign irq_done = irq_en & full;
  assign irq_err  = irq_en & (err_ovr | err_frm | err_par);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= IDLE; cnt <= '0; bidx <= '0; sr <= '0; armed <= 1'b0;
      rx_data <= '0; full <= 1'b0;
      err_ovr <= 1'b0; err_frm <= 1'b0; err_par <= 1'b0;
    end else begin
      if (stat_rd) armed <= 1'b1;
      if (clr_full_wr || clr_err_wr) armed <= 1'b0;
      if (clr_full_wr && armed) full <= 1'b0;
      if (clr_err_wr && armed) begin
        err_ovr <= 1'b0; err_frm <= 1'b0; err_par <= 1'b0;
      end
      if (xfer_rd) full <= 1'b0;

      case (st)
        IDLE: if (rx_en && tick16 && !rxd) begin st <= START; cnt <= '0; end
        START: if (tick16) begin
          cnt <= cnt + 1'b1;
          if (cnt == MID) begin
            cnt <= '0; bidx <= '0;
            st <= rxd ? IDLE : BITS;
          end
        end
        BITS: if (tick16) begin
          cnt <= (cnt == LAST) ? '0 : cnt + 1'b1;
          if (cnt == LAST) begin
            sr[bidx] <= rxd;
            bidx <= bidx + 4'd1;
            if (bidx == nbits - 4'd1) st <= DONE;
          end
        end
        default: begin
          st <= IDLE;
          if (full || par_bad || frm_bad) begin
            err_ovr <= err_ovr | full;
            err_par <= err_par | par_bad;
            err_frm <= err_frm | frm_bad;
          end else begin
            rx_data <= dat;
            full <= 1'b1;
          end
        end
      endcase
      if (!rx_en) st <= IDLE;
    end
  end

  a_r1_idle_when_off: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_en |=> st == IDLE);
  a_r4_bad_no_full: assert property (@(posedge clk) disable iff (!rst_n)
    (done && (par_bad || frm_bad)) |=> !$rose(full));
  a_r3_full_from_frame: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(full) |-> $past(done));
  a_r5_len7_msb: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !full && !par_bad && !frm_bad && cfg_len7) |=> !rx_data[7]);
  a_r9_overrun: assert property (@(posedge clk) disable iff (!rst_n)
    (done && full) |=> err_ovr && $stable(rx_data));
endmodule

// File: tb/tb_serial_rx_core.sv
`timescale 1ns/1ps
module tb_serial_rx_core;
  logic clk = 0, rst_n = 0;
  logic rx_en = 0, rxd = 1;
  logic cfg_len7 = 0, cfg_par_en = 0, cfg_par_odd = 0, cfg_two_stop = 0, cfg_chk_both = 0;
  logic irq_en = 1, stat_rd = 0, clr_full_wr = 0, clr_err_wr = 0, xfer_rd = 0;
  logic [7:0] rx_data;
  logic full, err_ovr, err_frm, err_par, irq_done, irq_err;
  logic [1:0] tcnt = 0;
  logic tick16;
  int errors = 0, checks = 0;
  bit finished = 0;

  always #5 clk = ~clk;
  always @(posedge clk) tcnt <= tcnt + 2'd1;
  assign tick16 = (tcnt == 2'd3);

  serial_rx_core dut (.*);

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bitout(input logic b);
    rxd = b; idle(64);
  endtask

  task automatic frame(input logic [7:0] d, input logic bad_par, input logic st1, input logic st2);
    int n;
    logic p;
    n = cfg_len7 ? 7 : 8;
    p = cfg_par_odd ^ bad_par;
    bitout(1'b0);
    for (int i = 0; i < n; i++) begin bitout(d[i]); p ^= d[i]; end
    if (cfg_par_en) bitout(p);
    bitout(st1);
    if (cfg_two_stop) bitout(st2);
    rxd = 1; idle(80);
  endtask

  task automatic pulse(ref logic s);
    s = 1; idle(1); s = 0; idle(1);
  endtask

  task automatic clear_all();
    pulse(stat_rd); pulse(clr_full_wr); pulse(stat_rd); pulse(clr_err_wr);
  endtask

  task automatic flags(input string req, input int f, input int o, input int fr, input int pa);
    chk(req, full, f); chk(req, err_ovr, o); chk(req, err_frm, fr); chk(req, err_par, pa);
  endtask

  task automatic t_reset();
    flags("reset", 0, 0, 0, 0);
    chk("reset data", rx_data, 0);
    chk("reset irq", {irq_done, irq_err}, 0);
  endtask

  task automatic t_disabled();
    rx_en = 0; frame(8'h3c, 0, 1, 1);
    flags("R1 disabled", 0, 0, 0, 0); chk("R1 data", rx_data, 0);
    rx_en = 1; idle(10);
  endtask

  task automatic t_glitch();
    rxd = 0; idle(12); rxd = 1; idle(200);
    flags("R2 false start", 0, 0, 0, 0);
  endtask

  task automatic t_good8();
    frame(8'ha5, 0, 1, 1);
    flags("R3 clean frame", 1, 0, 0, 0);
    chk("R3 data", rx_data, 8'ha5);
    chk("R12 irq_done", irq_done, 1); chk("R12 irq_err", irq_err, 0);
  endtask

  task automatic t_clear();
    pulse(clr_full_wr);
    chk("R10 write without read", full, 1);
    pulse(stat_rd); pulse(clr_full_wr);
    chk("R10 read then write", full, 0);
    chk("R12 irq_done low", irq_done, 0);
  endtask

  task automatic t_xfer();
    frame(8'h5a, 0, 1, 1);
    chk("R11 before", full, 1);
    pulse(xfer_rd);
    chk("R11 xfer read clears", full, 0);
  endtask

  task automatic t_len7();
    cfg_len7 = 1; cfg_par_en = 1; cfg_par_odd = 0;
    frame(8'hc3, 0, 1, 1);
    flags("R5 seven bit", 1, 0, 0, 0); chk("R5 msb zero", rx_data, 8'h43);
    pulse(xfer_rd);
    cfg_len7 = 0; cfg_par_en = 0;
  endtask

  task automatic t_parity();
    cfg_par_en = 1; cfg_par_odd = 1;
    frame(8'h81, 0, 1, 1);
    flags("R6 odd good", 1, 0, 0, 0); chk("R6 data", rx_data, 8'h81);
    pulse(xfer_rd);
    frame(8'h77, 1, 1, 1);
    flags("R6 parity error", 0, 0, 0, 1);
    chk("R4 data kept", rx_data, 8'h81);
    chk("R12 irq_err", irq_err, 1);
    irq_en = 0; idle(2);
    chk("R12 gated", {irq_done, irq_err}, 0);
    irq_en = 1;
    pulse(clr_err_wr);
    chk("R10 err write no read", err_par, 1);
    clear_all();
    flags("R10 errors cleared", 0, 0, 0, 0);
    cfg_par_en = 0; cfg_par_odd = 0;
  endtask

  task automatic t_framing();
    frame(8'h12, 0, 0, 1);
    flags("R7 framing", 0, 0, 1, 0); chk("R4 data kept", rx_data, 8'h81);
    clear_all();
  endtask

  task automatic t_two_stop();
    cfg_two_stop = 1; cfg_chk_both = 0;
    frame(8'h34, 0, 1, 0);
    flags("R8 first only", 1, 0, 0, 0); chk("R8 data", rx_data, 8'h34);
    pulse(xfer_rd);
    cfg_chk_both = 1;
    frame(8'h56, 0, 1, 0);
    flags("R8 both checked", 0, 0, 1, 0);
    clear_all();
    cfg_two_stop = 0; cfg_chk_both = 0;
  endtask

  task automatic t_overrun();
    frame(8'h11, 0, 1, 1);
    frame(8'h22, 0, 1, 1);
    flags("R9 overrun", 1, 1, 0, 0); chk("R9 old data", rx_data, 8'h11);
    clear_all();
  endtask

  initial begin
    #(200000 * 10);
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    idle(3); rst_n = 1; idle(2);
    t_reset();
    t_disabled();
    t_glitch();
    t_good8();
    t_clear();
    t_xfer();
    t_len7();
    t_parity();
    t_framing();
    t_two_stop();
    t_overrun();
    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule